// File: doc/BRIEF.md
# General-Purpose Timer with Prescaler

This block is a 32-bit timer peripheral on a simple register bus. A 3-bit field selects one of several tick sources. Each source reaches the block as a one-cycle enable strobe in the system clock domain. The selected ticks pass through a prescaler and advance a free-running up-counter. Software can read the counter at any time.

When the counter wraps from all ones to zero, it sets a rollover flag in the status register. Software clears the flag by writing 1 to it. An interrupt-enable register uses the same bit layout as the status register, and the interrupt output goes high when a flag and its enable bit are both set.

The fast source has two extra conditions: it needs its own enable bit, and it passes through a second divider before the main prescaler. Four low-power and debug mode inputs can freeze counting unless the matching control bit allows counting in that mode. A software reset bit clears itself after a fixed number of cycles. It wipes every register except the enable and mode bits of the control register.

Top module: `gp_timer`

## Requirements
- R1: After `rst_ni` is released, control (0x00), prescaler (0x04), status (0x08), interrupt enable (0x0C) and counter (0x24) all read 0, and `irq_o` is low. Unmapped addresses always read 0.
- R2: Control bits 8:6 select the tick source: 1 `per_tick_i`, 2 `per_hi_tick_i`, 3 `ext_tick_i`, 4 `slow_tick_i`, 5 `fast_tick_i`. Codes 0, 6 and 7 select no source, and the counter holds. The defined control bits read back as written.
- R3: Source 5 produces no ticks unless control bit 10 is set.
- R4: Prescaler bits 11:0 hold a value P. The counter advances once per P+1 qualified ticks.
- R5: Prescaler bits 15:12 hold a value F. It divides the fast source by F+1 ahead of the main prescaler and has no effect on any other source.
- R6: Control bits 5, 4, 3 and 2 allow counting while `stop_i`, `doze_i`, `wait_i` or `dbg_i` is high, in that order. When a bit is 0 and its input is high, the counter holds.
- R7: Control bit 0 enables counting, and the counter holds its value while bit 0 is 0. A write that takes bit 0 from 0 to 1 with bit 1 set clears the counter and both dividers. With bit 1 clear, the same write keeps the count.
- R8: The counter wraps from all ones to 0 and sets status bit 0. Writes to the counter address are ignored. Control bit 9 is stored and read back.
- R9: Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged.
- R10: `irq_o` is high exactly when status bit 0 and interrupt-enable bit 0 are both 1.
- R11: Writing 1 to control bit 15 makes that bit read 1 for SWR_CYCLES cycles, with counting halted. The bit then clears. At that point control bits 5:0 keep their values and every other register bit becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| per_tick_i | input | 1 | Peripheral clock tick strobe |
| per_hi_tick_i | input | 1 | High-frequency peripheral clock tick strobe |
| ext_tick_i | input | 1 | External clock tick strobe |
| slow_tick_i | input | 1 | 32.768 kHz tick strobe |
| fast_tick_i | input | 1 | 24 MHz tick strobe |
| stop_i | input | 1 | Stop mode active |
| doze_i | input | 1 | Doze mode active |
| wait_i | input | 1 | Wait mode active |
| dbg_i | input | 1 | Debug mode active |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the timer with CNT_W = 8. This puts the wrap to zero, the rollover flag and the interrupt within 256 ticks instead of four billion. SWR_CYCLES stays at 3, so the self-clearing reset can be sampled both while it is busy and after it has finished. The prescaler widths stay at 12 and 4 bits so the register field positions match the full layout. Random runs then draw the source, P and F together and compare the counter against a model built from the two nested divisions.

// File: rtl/gp_timer_pkg.sv
`timescale 1ns/1ps
package gp_timer_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam logic [ADDR_W-1:0] A_CTRL = 6'h00;
  localparam logic [ADDR_W-1:0] A_PRE  = 6'h04;
  localparam logic [ADDR_W-1:0] A_STAT = 6'h08;
  localparam logic [ADDR_W-1:0] A_IEN  = 6'h0C;
  localparam logic [ADDR_W-1:0] A_CNT  = 6'h24;

  localparam int unsigned B_EN = 0, B_ENMOD = 1, B_DBGEN = 2, B_WAITEN = 3;
  localparam int unsigned B_DOZEEN = 4, B_STOPEN = 5, B_SEL = 6;
  localparam int unsigned B_FRR = 9, B_FASTEN = 10, B_SWR = 15;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0, SRC_PER = 3'd1, SRC_PER_HI = 3'd2,
    SRC_EXT = 3'd3, SRC_SLOW = 3'd4, SRC_FAST = 3'd5
  } src_e;

  typedef struct packed {
    logic swr;
    logic fast_en;
    logic frr;
    src_e sel;
    logic stop_en;
    logic doze_en;
    logic wait_en;
    logic dbg_en;
    logic enmod;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/gp_timer_regs.sv
`timescale 1ns/1ps
module gp_timer_regs
  import gp_timer_pkg::*;
#(
  parameter int unsigned PRE_W      = 12,
  parameter int unsigned FPRE_W     = 4,
  parameter int unsigned SWR_CYCLES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              rov_i,
  output ctrl_t             ctrl_o,
  output logic [PRE_W-1:0]  pre_o,
  output logic [FPRE_W-1:0] fpre_o,
  output logic              ien_o,
  output logic              stat_o,
  output logic              restart_o,
  output logic              swr_done_o
);
  localparam int unsigned SC_W = (SWR_CYCLES > 1) ? $clog2(SWR_CYCLES) : 1;
  localparam logic [SC_W-1:0] SC_LAST = SC_W'(SWR_CYCLES - 1);

  ctrl_t            ctrl_q, wr_ctrl, kept;
  logic [SC_W-1:0]  sc_q;
  logic             wr;

  assign wr = we_i && !ctrl_q.swr;  // bus writes dropped while reset runs

  always_comb begin
    wr_ctrl         = '0;
    wr_ctrl.swr     = wdata_i[B_SWR];
    wr_ctrl.fast_en = wdata_i[B_FASTEN];
    wr_ctrl.frr     = wdata_i[B_FRR];
    wr_ctrl.sel     = src_e'(wdata_i[B_SEL +: 3]);
    wr_ctrl.stop_en = wdata_i[B_STOPEN];
    wr_ctrl.doze_en = wdata_i[B_DOZEEN];
    wr_ctrl.wait_en = wdata_i[B_WAITEN];
    wr_ctrl.dbg_en  = wdata_i[B_DBGEN];
    wr_ctrl.enmod   = wdata_i[B_ENMOD];
    wr_ctrl.en      = wdata_i[B_EN];
    kept            = '0;
    kept.stop_en    = ctrl_q.stop_en;
    kept.doze_en    = ctrl_q.doze_en;
    kept.wait_en    = ctrl_q.wait_en;
    kept.dbg_en     = ctrl_q.dbg_en;
    kept.enmod      = ctrl_q.enmod;
    kept.en         = ctrl_q.en;
  end

  assign swr_done_o = ctrl_q.swr && (sc_q == SC_LAST);
  assign restart_o  = wr && (addr_i == A_CTRL) && wdata_i[B_EN] &&
                      wdata_i[B_ENMOD] && !ctrl_q.en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      pre_o  <= '0;
      fpre_o <= '0;
      ien_o  <= 1'b0;
      stat_o <= 1'b0;
      sc_q   <= '0;
    end else if (swr_done_o) begin
      ctrl_q <= kept;
      pre_o  <= '0;
      fpre_o <= '0;
      ien_o  <= 1'b0;
      stat_o <= 1'b0;
      sc_q   <= '0;
    end else begin
      sc_q <= ctrl_q.swr ? sc_q + 1'b1 : '0;
      if (wr && addr_i == A_CTRL) ctrl_q <= wr_ctrl;
      if (wr && addr_i == A_PRE) begin
        pre_o  <= wdata_i[PRE_W-1:0];
        fpre_o <= wdata_i[PRE_W +: FPRE_W];
      end
      if (wr && addr_i == A_IEN) ien_o <= wdata_i[0];
      if (rov_i) stat_o <= 1'b1;
      else if (wr && addr_i == A_STAT && wdata_i[0]) stat_o <= 1'b0;
    end
  end

  assign ctrl_o = ctrl_q;

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[31:PRE_W+FPRE_W], wdata_i[14:11]};
endmodule

// File: rtl/gp_timer_div.sv
`timescale 1ns/1ps
module gp_timer_div #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         pulse_o
);
  logic [W-1:0] cnt_q;

  assign pulse_o = tick_i && (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= pulse_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/gp_timer_tick.sv
`timescale 1ns/1ps
module gp_timer_tick
  import gp_timer_pkg::*;
#(
  parameter int unsigned PRE_W  = 12,
  parameter int unsigned FPRE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        src_i,
  input  ctrl_t             ctrl_i,
  input  logic [PRE_W-1:0]  pre_i,
  input  logic [FPRE_W-1:0] fpre_i,
  input  logic              stop_i,
  input  logic              doze_i,
  input  logic              wait_i,
  input  logic              dbg_i,
  input  logic              clr_i,
  output logic              adv_o
);
  logic run, raw, fast_in, fast_pulse, main_in;

  assign run = ctrl_i.en && !ctrl_i.swr &&
               !(stop_i && !ctrl_i.stop_en) && !(doze_i && !ctrl_i.doze_en) &&
               !(wait_i && !ctrl_i.wait_en) && !(dbg_i && !ctrl_i.dbg_en);

  always_comb begin
    case (ctrl_i.sel)
      SRC_PER:    raw = src_i[0];
      SRC_PER_HI: raw = src_i[1];
      SRC_EXT:    raw = src_i[2];
      SRC_SLOW:   raw = src_i[3];
      default:    raw = 1'b0;
    endcase
  end

  assign fast_in = run && ctrl_i.fast_en && src_i[4] && (ctrl_i.sel == SRC_FAST);

  gp_timer_div #(.W(FPRE_W)) u_fdiv (
    .clk_i, .rst_ni, .clr_i, .tick_i(fast_in), .limit_i(fpre_i), .pulse_o(fast_pulse)
  );

  assign main_in = (ctrl_i.sel == SRC_FAST) ? fast_pulse : (run && raw);

  gp_timer_div #(.W(PRE_W)) u_pdiv (
    .clk_i, .rst_ni, .clr_i, .tick_i(main_in), .limit_i(pre_i), .pulse_o(adv_o)
  );

  logic unused_ctrl;
  assign unused_ctrl = ^{ctrl_i.frr, ctrl_i.enmod};
endmodule

// File: rtl/gp_timer_count.sv
`timescale 1ns/1ps
module gp_timer_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             rov_o
);
  assign rov_o = adv_i && (&cnt_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (adv_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/gp_timer.sv
`timescale 1ns/1ps
module gp_timer
  import gp_timer_pkg::*;
#(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned PRE_W      = 12,
  parameter int unsigned FPRE_W     = 4,
  parameter int unsigned SWR_CYCLES = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [5:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        per_tick_i,
  input  logic        per_hi_tick_i,
  input  logic        ext_tick_i,
  input  logic        slow_tick_i,
  input  logic        fast_tick_i,
  input  logic        stop_i,
  input  logic        doze_i,
  input  logic        wait_i,
  input  logic        dbg_i,
  output logic        irq_o
);
  ctrl_t             ctrl;
  logic [PRE_W-1:0]  pre;
  logic [FPRE_W-1:0] fpre;
  logic              ien, stat, restart, swr_done, swr_busy, clr, adv, rov;
  logic [CNT_W-1:0]  cnt;

  gp_timer_regs #(.PRE_W(PRE_W), .FPRE_W(FPRE_W), .SWR_CYCLES(SWR_CYCLES)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rov_i(rov),
    .ctrl_o(ctrl), .pre_o(pre), .fpre_o(fpre), .ien_o(ien), .stat_o(stat),
    .restart_o(restart), .swr_done_o(swr_done)
  );

  assign swr_busy = ctrl.swr;
  assign clr      = restart || swr_done;

  gp_timer_tick #(.PRE_W(PRE_W), .FPRE_W(FPRE_W)) u_tick (
    .clk_i, .rst_ni,
    .src_i({fast_tick_i, slow_tick_i, ext_tick_i, per_hi_tick_i, per_tick_i}),
    .ctrl_i(ctrl), .pre_i(pre), .fpre_i(fpre),
    .stop_i, .doze_i, .wait_i, .dbg_i, .clr_i(clr), .adv_o(adv)
  );

  gp_timer_count #(.CNT_W(CNT_W)) u_count (
    .clk_i, .rst_ni, .clr_i(clr), .adv_i(adv), .cnt_o(cnt), .rov_o(rov)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[B_SWR]       = ctrl.swr;
        rdata_o[B_FASTEN]    = ctrl.fast_en;
        rdata_o[B_FRR]       = ctrl.frr;
        rdata_o[B_SEL +: 3]  = ctrl.sel;
        rdata_o[B_STOPEN]    = ctrl.stop_en;
        rdata_o[B_DOZEEN]    = ctrl.doze_en;
        rdata_o[B_WAITEN]    = ctrl.wait_en;
        rdata_o[B_DBGEN]     = ctrl.dbg_en;
        rdata_o[B_ENMOD]     = ctrl.enmod;
        rdata_o[B_EN]        = ctrl.en;
      end
      A_PRE: begin
        rdata_o[PRE_W-1:0]     = pre;
        rdata_o[PRE_W +: FPRE_W] = fpre;
      end
      A_STAT:  rdata_o[0] = stat;
      A_IEN:   rdata_o[0] = ien;
      A_CNT:   rdata_o[CNT_W-1:0] = cnt;
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = stat && ien;
endmodule

// File: rtl/gp_timer_sva.sv
`timescale 1ns/1ps
module gp_timer_sva #(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned SWR_CYCLES = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic [5:0]       addr_i,
  input logic             wdata0_i,
  input logic             stop_i,
  input logic             stop_en_i,
  input logic [2:0]       sel_i,
  input logic             swr_busy_i,
  input logic             stat_i,
  input logic             ien_i,
  input logic             rov_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             irq_o
);
  int unsigned busy_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         busy_len <= 0;
    else if (swr_busy_i) busy_len <= busy_len + 1;
    else                 busy_len <= 0;
  end

  a_r6_stop_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !stop_en_i && !swr_busy_i && !we_i) |=> $stable(cnt_i));

  a_r2_no_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'd0 && !swr_busy_i && !we_i) |=> $stable(cnt_i));

  a_r8_rov_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rov_i |=> stat_i);

  a_r9_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 6'h08 && wdata0_i && !rov_i && !swr_busy_i) |=> !stat_i);

  a_r10_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ien_i |-> !irq_o);

  a_r11_swr_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swr_busy_i |-> (busy_len < SWR_CYCLES));

  a_r11_swr_wipe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(swr_busy_i) |-> (cnt_i == '0 && !stat_i && !ien_i));
endmodule

bind gp_timer gp_timer_sva #(.CNT_W(CNT_W), .SWR_CYCLES(SWR_CYCLES)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
  .wdata0_i(wdata_i[0]), .stop_i(stop_i), .stop_en_i(ctrl.stop_en),
  .sel_i(ctrl.sel), .swr_busy_i(swr_busy), .stat_i(stat), .ien_i(ien),
  .rov_i(rov), .cnt_i(cnt), .irq_o(irq_o)
);

// File: tb/gp_timer_test.sv
`timescale 1ns/1ps
module gp_timer_test;
  localparam int CNT_W = 8;
  localparam logic [5:0] A_CTRL = 6'h00, A_PRE = 6'h04, A_STAT = 6'h08,
                         A_IEN = 6'h0C, A_CNT = 6'h24;

  logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [4:0]  src = '0;
  logic [3:0]  mode = '0;  // stop, doze, wait, dbg
  logic        irq;
  int          n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  gp_timer #(.CNT_W(CNT_W), .PRE_W(12), .FPRE_W(4), .SWR_CYCLES(3)) uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .per_tick_i(src[0]), .per_hi_tick_i(src[1]),
    .ext_tick_i(src[2]), .slow_tick_i(src[3]), .fast_tick_i(src[4]),
    .stop_i(mode[0]), .doze_i(mode[1]), .wait_i(mode[2]), .dbg_i(mode[3]),
    .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic ticks(input int n, input logic [4:0] mask, input bit rnd,
                       input int idx, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      src = rnd ? (5'($urandom) & mask) : mask;
      if (src[idx]) hits++;
    end
    @(negedge clk); src = '0;
  endtask

  function automatic logic [31:0] cfg(int sel, bit fen, bit enmod, bit en);
    return (32'(sel) << 6) | (32'(fen) << 10) | (32'(enmod) << 1) | 32'(en);
  endfunction

  function automatic logic [31:0] exp_cnt(int h, int p, int f, bit fast);
    int t;
    t = fast ? h / (f + 1) : h;
    return 32'((t / (p + 1)) % (1 << CNT_W));
  endfunction

  task automatic fresh(input int sel, input bit fen);
    wr(A_CTRL, cfg(sel, fen, 1'b1, 1'b0));
    wr(A_CTRL, cfg(sel, fen, 1'b1, 1'b1));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int h, sel, p, f;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_CTRL, v); check("R1 ctrl", v, 0);
    rd(A_PRE, v);  check("R1 pre", v, 0);
    rd(A_STAT, v); check("R1 stat", v, 0);
    rd(A_IEN, v);  check("R1 ien", v, 0);
    rd(A_CNT, v);  check("R1 cnt", v, 0);
    check("R1 irq", 32'(irq), 0);
    rd(6'h10, v);  check("R1 unmapped", v, 0);

    // R2 readback, no-source codes
    wr(A_CTRL, 32'h7FC); rd(A_CTRL, v); check("R2 ctrl readback", v, 32'h7FC);
    fresh(0, 1'b1); ticks(8, 5'h1F, 0, 0, h); rd(A_CNT, v); check("R2 sel0", v, 0);
    fresh(6, 1'b1); ticks(8, 5'h1F, 0, 0, h); rd(A_CNT, v); check("R2 sel6", v, 0);

    // R4 prescaler
    wr(A_PRE, 0); fresh(1, 1'b0); ticks(10, 5'h01, 0, 0, h);
    rd(A_CNT, v); check("R4 p0", v, 10);
    wr(A_PRE, 3); fresh(1, 1'b0); ticks(13, 5'h01, 0, 0, h);
    rd(A_CNT, v); check("R4 p3", v, 3);

    // R3 fast enable
    wr(A_PRE, 32'h1000); fresh(5, 1'b0); ticks(6, 5'h10, 0, 4, h);
    rd(A_CNT, v); check("R3 fast off", v, 0);
    fresh(5, 1'b1); ticks(10, 5'h10, 0, 4, h);
    rd(A_CNT, v); check("R3 fast on f1", v, 5);

    // R5 fast divider ignored elsewhere
    wr(A_PRE, 32'h3000); fresh(1, 1'b1); ticks(7, 5'h01, 0, 0, h);
    rd(A_CNT, v); check("R5 f ignored", v, 7);

    // R6 mode gating
    wr(A_PRE, 0);
    for (int k = 0; k < 4; k++) begin
      fresh(1, 1'b0);
      @(negedge clk); mode = 4'(1 << k);
      ticks(4, 5'h01, 0, 0, h); rd(A_CNT, v); check("R6 frozen", v, 0);
      wr(A_CTRL, cfg(1, 1'b0, 1'b1, 1'b1) | (32'h1 << (5 - k)));
      ticks(4, 5'h01, 0, 0, h); rd(A_CNT, v); check("R6 allowed", v, 4);
      @(negedge clk); mode = '0;
    end

    // R7 enable / restart
    fresh(1, 1'b0); ticks(6, 5'h01, 0, 0, h);
    wr(A_CTRL, cfg(1, 1'b0, 1'b0, 1'b0)); ticks(3, 5'h01, 0, 0, h);
    rd(A_CNT, v); check("R7 hold when off", v, 6);
    wr(A_CTRL, cfg(1, 1'b0, 1'b0, 1'b1)); ticks(3, 5'h01, 0, 0, h);
    rd(A_CNT, v); check("R7 keep w/o enmod", v, 9);
    wr(A_CTRL, cfg(1, 1'b0, 1'b0, 1'b0)); wr(A_CTRL, cfg(1, 1'b0, 1'b1, 1'b1));
    rd(A_CNT, v); check("R7 restart clears", v, 0);

    // R8 rollover, R9 w1c, R10 irq
    fresh(1, 1'b0); wr(A_IEN, 1);
    ticks(255, 5'h01, 0, 0, h);
    rd(A_CNT, v); check("R8 cnt max", v, 255);
    rd(A_STAT, v); check("R8 no flag yet", v, 0);
    check("R10 irq low", 32'(irq), 0);
    ticks(1, 5'h01, 0, 0, h);
    rd(A_CNT, v); check("R8 wrap", v, 0);
    rd(A_STAT, v); check("R8 flag", v, 1);
    check("R10 irq high", 32'(irq), 1);
    wr(A_CNT, 32'h55); rd(A_CNT, v); check("R8 cnt read-only", v, 0);
    wr(A_STAT, 0); rd(A_STAT, v); check("R9 write0 keeps", v, 1);
    wr(A_IEN, 0); #1 check("R10 masked", 32'(irq), 0);
    wr(A_IEN, 1); #1 check("R10 unmasked", 32'(irq), 1);
    wr(A_STAT, 1); rd(A_STAT, v); check("R9 cleared", v, 0);
    check("R10 irq after clear", 32'(irq), 0);

    // R11 software reset
    wr(A_PRE, 32'h3005); ticks(5, 5'h01, 0, 0, h);
    wr(A_CTRL, 32'h8000 | 32'h600 | cfg(1, 1'b1, 1'b0, 1'b1) | 32'h3C);
    rd(A_CTRL, v); check("R11 busy", 32'(v[15]), 1);
    repeat (4) @(negedge clk);
    rd(A_CTRL, v); check("R11 ctrl kept bits", v, 32'h3D);
    rd(A_PRE, v);  check("R11 pre wiped", v, 0);
    rd(A_IEN, v);  check("R11 ien wiped", v, 0);
    rd(A_CNT, v);  check("R11 cnt wiped", v, 0);

    // random sources and dividers (R2 R4 R5)
    for (int it = 0; it < 24; it++) begin
      sel = 1 + int'($urandom % 5);
      p = int'($urandom % 4);
      f = int'($urandom % 3);
      wr(A_PRE, (32'(f) << 12) | 32'(p));
      fresh(sel, 1'b1);
      ticks(5 + int'($urandom % 40), 5'h1F, 1, sel - 1, h);
      rd(A_CNT, v);
      check("R4 R5 random", v, exp_cnt(h, p, f, sel == 5));
    end

    finish_run();
  end
endmodule